// File: doc/BRIEF.md
# HDLC Receive Byte Queue with Special-Condition Interrupt

This block is the receive half of an HDLC controller, placed after the deframer. Each byte that the deframer delivers carries two tags: one marks the final byte before the closing flag, and one marks a frame that ended short, meaning it had fewer than 32 bits between its flags. Accepted bytes go into a small first-in first-out queue. The oldest entry is the receive data register that the CPU reads, and each CPU read pops that entry.

The block tracks three special receive conditions: overrun, end of frame and short frame. Any of these can raise one special-condition interrupt. While that interrupt is pending, the queue and its head are frozen until software issues an error-reset command. The error reset clears the conditions but leaves the queued bytes in place. A separate flush input empties the queue without touching the conditions.

An interrupt mode selects when an end of frame counts as an event and how the receive-data interrupt behaves. A read-only monitor byte shows four live interrupt lines.

Top module: `hdlc_rx_queue`

## Requirements
- R1: Accepted bytes leave the queue in arrival order. While `rx_avail` is 1, `rd_data` shows the oldest byte. A one-cycle `rd_strobe` pops that byte, and the queue holds up to 4 bytes.
- R2: A byte that arrives while the queue is full and no pop happens in the same cycle replaces the newest entry. A byte that arrives while `sp_int` is 1 is dropped. Both cases set `rx_status[7]` (overrun), which stays set until an error reset.
- R3: `rx_status[0]` (short frame) is set one cycle after a byte with the short tag becomes the head. When `rx_status[7]` or `rx_status[0]` is 1, `sp_int` is 1 in every mode.
- R4: With `int_mode`=3 (threshold) and `rx_threshold`=0, `rx_status[6]` (end of frame) and `sp_int` rise one cycle after a last-tagged byte becomes the head. Accepting that byte behind other bytes does not set them.
- R5: With `int_mode`=3 and a nonzero threshold, `rx_status[6]` and `sp_int` rise one cycle after a last-tagged byte is accepted into the queue, even when the byte is not at the head.
- R6: With `int_mode`=1 (first character) or 2 (special only), `rx_status[6]` and `sp_int` rise one cycle after the CPU pops a last-tagged byte. Accepting that byte does not set them.
- R7: With `int_mode`=0 (off), `rx_status[6]` is set when a last-tagged byte becomes the head, and `sp_int` stays 0.
- R8: `rx_status[6]` clears when the first byte of the next frame is accepted, that is, the first byte after a last-tagged byte.
- R9: While `sp_int` is 1, `rd_strobe` pops nothing, and `rd_data` and `rx_avail` hold their values.
- R10: One cycle after `err_reset`, all status bits and `sp_int` are 0, and the queued bytes and head are unchanged.
- R11: One cycle after `queue_flush`, the queue is empty. The status bits are kept, and the flush works even while the queue is locked.
- R12: `rx_int` depends on the mode. In mode 3 it equals (queued count > `rx_threshold`). In mode 1 it equals `rx_avail`. In modes 0 and 2 it is 0.
- R13: `int_monitor` is {`es_int_in`, `sp_int`, `rx_int`, `tx_int_in`, 4'b0000}, from bit 7 down to bit 0, and always shows the current values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Byte from the deframer is valid this cycle |
| rx_data | input | 8 | Received byte |
| rx_last | input | 1 | Byte is the last one before the closing flag |
| rx_short | input | 1 | Byte ends a frame shorter than 32 bits |
| rd_strobe | input | 1 | CPU read of the receive data register (pops head) |
| err_reset | input | 1 | Error-reset command pulse |
| queue_flush | input | 1 | Reset-receive-queue command pulse |
| int_mode | input | 2 | 0 off, 1 first character, 2 special only, 3 threshold |
| rx_threshold | input | 2 | Queue threshold for mode 3 |
| es_int_in | input | 1 | External/status interrupt line, for the monitor |
| tx_int_in | input | 1 | Transmit interrupt line, for the monitor |
| rd_data | output | 8 | Head byte of the queue |
| rx_avail | output | 1 | Queue holds at least one byte |
| rx_status | output | 8 | Bit 7 overrun, bit 6 end of frame, bit 0 short frame, others 0 |
| int_monitor | output | 8 | Live interrupt view, bits 7..4 |
| sp_int | output | 1 | Special-condition interrupt request (also the queue lock) |
| rx_int | output | 1 | Receive-data interrupt request |

## Verification
The assertions assume that `err_reset` and `queue_flush` are single-cycle commands that never coincide with each other. They also assume that `int_mode` and `rx_threshold` change only while the queue is idle, because the end-of-frame event selection is evaluated in the cycle of each push or pop. The stimulus drives every command as a one-cycle pulse. It changes the mode only between groups of traffic, once the queue has been drained and the status cleared, so every group starts from an empty queue with no pending condition.

// File: rtl/hdlc_rxq_pkg.sv
// Package: shared types for the HDLC receive queue.
// Assumes 8-bit bytes from the deframer.
package hdlc_rxq_pkg;

    localparam int BYTE_W = 8;

    // One queue slot: the byte together with its frame tags
    typedef struct packed {
        logic              last;
        logic              short_f;
        logic [BYTE_W-1:0] data;
    } rxq_entry_t;

    // Interrupt mode encoding seen on int_mode
    typedef enum logic [1:0] {
        MODE_OFF     = 2'd0,
        MODE_FIRST   = 2'd1,
        MODE_SPECIAL = 2'd2,
        MODE_THRESH  = 2'd3
    } rx_mode_e;

endpackage

// File: rtl/hdlc_rxq_store.sv
// Module: tagged byte FIFO with head and second-entry views.
// Assumes DEPTH >= 2; the caller never asserts wr_en with a full queue
// (it uses ovw_en instead) nor rd_en on an empty queue.
module hdlc_rxq_store
    import hdlc_rxq_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             ovw_en,
    input  rxq_entry_t       wr_ent,
    input  logic             rd_en,
    input  logic             flush,
    output rxq_entry_t       head_ent,
    output rxq_entry_t       next_ent,
    output logic [CNT_W-1:0] count
);

    rxq_entry_t       mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    function automatic logic [PTR_W-1:0] ptr_fwd(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [PTR_W-1:0] ptr_back(input logic [PTR_W-1:0] p);
        return (p == '0) ? PTR_W'(DEPTH - 1) : p - 1'b1;
    endfunction

    // Slot storage, pointer and occupancy update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_en) begin
                mem[wr_ptr] <= wr_ent;
                wr_ptr      <= ptr_fwd(wr_ptr);
            end
            if (ovw_en) mem[ptr_back(wr_ptr)] <= wr_ent;
            if (rd_en) rd_ptr <= ptr_fwd(rd_ptr);
            case ({wr_en, rd_en})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Head and the entry that becomes head on the next pop
    assign head_ent = mem[rd_ptr];
    assign next_ent = mem[ptr_fwd(rd_ptr)];

endmodule

// File: rtl/hdlc_rxq_event_sel.sv
// Module: picks the end-of-frame event and the receive interrupt per mode.
// Assumes mode and threshold are steady while traffic flows.
module hdlc_rxq_event_sel
    import hdlc_rxq_pkg::*;
#(
    parameter int CNT_W = 3,
    parameter int THR_W = 2
) (
    input  rx_mode_e         mode,
    input  logic [THR_W-1:0] threshold,
    input  logic [CNT_W-1:0] count,
    input  logic             head_last,
    input  logic             push_last,
    input  logic             read_last,
    output logic             eof_set,
    output logic             eof_irq_en,
    output logic             rx_int
);

    // End-of-frame timing point and interrupt enable for each mode
    always_comb begin
        eof_set    = 1'b0;
        eof_irq_en = 1'b0;
        rx_int     = 1'b0;
        case (mode)
            MODE_OFF: begin
                eof_set = head_last;
            end
            MODE_FIRST: begin
                eof_set    = read_last;
                eof_irq_en = 1'b1;
                rx_int     = (count != '0);
            end
            MODE_SPECIAL: begin
                eof_set    = read_last;
                eof_irq_en = 1'b1;
            end
            default: begin
                eof_set    = (threshold == '0) ? head_last : push_last;
                eof_irq_en = 1'b1;
                rx_int     = (32'(count) > 32'(threshold));
            end
        endcase
    end

endmodule

// File: rtl/hdlc_rxq_status.sv
// Module: sticky special-condition flags and the special interrupt request.
// Assumes err_reset is a single-cycle command; clearing wins over setting.
module hdlc_rxq_status (
    input  logic clk,
    input  logic rst_n,
    input  logic ovr_set,
    input  logic short_set,
    input  logic eof_set,
    input  logic eof_irq_en,
    input  logic frame_start,
    input  logic err_reset,
    output logic ovr,
    output logic short_f,
    output logic eof,
    output logic sp_req
);

    logic eof_irq;

    // Flag set, hold and clear
    always_ff @(posedge clk) begin
        if (!rst_n || err_reset) begin
            ovr     <= 1'b0;
            short_f <= 1'b0;
            eof     <= 1'b0;
            eof_irq <= 1'b0;
        end else begin
            ovr     <= ovr | ovr_set;
            short_f <= short_f | short_set;
            if (eof_set)          eof <= 1'b1;
            else if (frame_start) eof <= 1'b0;
            eof_irq <= eof_irq | (eof_set & eof_irq_en);
        end
    end

    // Any pending condition requests the special interrupt
    assign sp_req = ovr | short_f | eof_irq;

endmodule

// File: rtl/hdlc_rx_queue.sv
// Module: HDLC receive queue top. Accepts tagged bytes, exposes the head
// as the data register, derives special conditions and locks the queue
// while the special interrupt is pending.
// Assumes one byte per cycle at most and DEPTH >= 2.
module hdlc_rx_queue
    import hdlc_rxq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int THR_W = 2,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    input  logic             rx_last,
    input  logic             rx_short,
    input  logic             rd_strobe,
    input  logic             err_reset,
    input  logic             queue_flush,
    input  logic [1:0]       int_mode,
    input  logic [THR_W-1:0] rx_threshold,
    input  logic             es_int_in,
    input  logic             tx_int_in,
    output logic [7:0]       rd_data,
    output logic             rx_avail,
    output logic [7:0]       rx_status,
    output logic [7:0]       int_monitor,
    output logic             sp_int,
    output logic             rx_int
);

    rxq_entry_t       in_ent, head_ent, next_ent, arrive_ent;
    logic [CNT_W-1:0] q_count;
    logic             full, empty, more_than_one;
    logic             push_ok, pop_ok, ovw, wr;
    logic             head_chg, after_last;
    logic             eof_set, eof_irq_en;
    logic             st_ovr, st_short, st_eof;

    // Incoming slot and queue-state decode
    always_comb begin
        in_ent.last    = rx_last;
        in_ent.short_f = rx_short;
        in_ent.data    = rx_data;
        full           = (q_count == CNT_W'(DEPTH));
        empty          = (q_count == '0);
        more_than_one  = (q_count > CNT_W'(1));
    end

    // Push/pop gating: the pending special interrupt freezes the queue
    always_comb begin
        pop_ok   = rd_strobe & ~sp_int & ~empty & ~queue_flush;
        push_ok  = rx_valid & ~sp_int & ~queue_flush;
        ovw      = push_ok & full & ~pop_ok;
        wr       = push_ok & ~ovw;
        head_chg = (empty & push_ok) | (pop_ok & (more_than_one | push_ok));
        arrive_ent = (pop_ok & more_than_one) ? next_ent : in_ent;
    end

    // Remembers whether the last accepted byte closed a frame
    always_ff @(posedge clk) begin
        if (!rst_n || queue_flush) after_last <= 1'b0;
        else if (push_ok)          after_last <= rx_last;
    end

    hdlc_rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr),
        .ovw_en   (ovw),
        .wr_ent   (in_ent),
        .rd_en    (pop_ok),
        .flush    (queue_flush),
        .head_ent (head_ent),
        .next_ent (next_ent),
        .count    (q_count)
    );

    hdlc_rxq_event_sel #(.CNT_W(CNT_W), .THR_W(THR_W)) u_evsel (
        .mode       (rx_mode_e'(int_mode)),
        .threshold  (rx_threshold),
        .count      (q_count),
        .head_last  (head_chg & arrive_ent.last),
        .push_last  (push_ok & rx_last),
        .read_last  (pop_ok & head_ent.last),
        .eof_set    (eof_set),
        .eof_irq_en (eof_irq_en),
        .rx_int     (rx_int)
    );

    hdlc_rxq_status u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .ovr_set     (ovw | (rx_valid & sp_int & ~queue_flush)),
        .short_set   (head_chg & arrive_ent.short_f),
        .eof_set     (eof_set),
        .eof_irq_en  (eof_irq_en),
        .frame_start (push_ok & after_last),
        .err_reset   (err_reset),
        .ovr         (st_ovr),
        .short_f     (st_short),
        .eof         (st_eof),
        .sp_req      (sp_int)
    );

    // Register views toward the CPU
    assign rd_data     = head_ent.data;
    assign rx_avail    = ~empty;
    assign rx_status   = {st_ovr, st_eof, 5'b00000, st_short};
    assign int_monitor = {es_int_in, sp_int, rx_int, tx_int_in, 4'b0000};

endmodule

// File: rtl/hdlc_rxq_checker.sv
// Module: property checker for hdlc_rx_queue, attached by bind.
// Assumes err_reset and queue_flush never coincide.
module hdlc_rxq_checker #(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_valid,
    input logic             err_reset,
    input logic             queue_flush,
    input logic [1:0]       int_mode,
    input logic [CNT_W-1:0] q_count,
    input logic [7:0]       rd_data,
    input logic             rx_avail,
    input logic [7:0]       rx_status,
    input logic             sp_int,
    input logic             rx_int
);

    // Byte arriving on a locked queue marks overrun
    assert_locked_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && sp_int && !err_reset && !queue_flush |=> rx_status[7]);

    // Overrun stays until the error reset
    assert_ovr_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_status[7] && !err_reset |=> rx_status[7]);

    // Overrun or short frame always requests the special interrupt
    assert_cond_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_status[7] || rx_status[0]) |-> sp_int);

    // Locked queue keeps its head
    assert_lock_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sp_int && !err_reset && !queue_flush |=> $stable(rd_data) && $stable(rx_avail));

    // Error reset clears every condition
    assert_err_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_reset |=> (rx_status == 8'h00) && !sp_int);

    // Error reset keeps queue occupancy
    assert_err_keeps_q_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_reset && !queue_flush && !rx_valid |=> $stable(q_count));

    // Flush empties the queue
    assert_flush_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
        queue_flush |=> !rx_avail);

    // Special-only mode never raises the receive interrupt
    assert_rxint_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        int_mode == 2'd2 |-> !rx_int);

    // Occupancy never exceeds depth
    assert_depth_R1: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= CNT_W'(DEPTH));

endmodule

bind hdlc_rx_queue hdlc_rxq_checker #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_valid    (rx_valid),
    .err_reset   (err_reset),
    .queue_flush (queue_flush),
    .int_mode    (int_mode),
    .q_count     (q_count),
    .rd_data     (rd_data),
    .rx_avail    (rx_avail),
    .rx_status   (rx_status),
    .sp_int      (sp_int),
    .rx_int      (rx_int)
);

// File: tb/hdlc_rx_queue_bench.sv
// Bench for hdlc_rx_queue: a vector table in threshold mode, then directed
// tests for each end-of-frame timing, locking, overrun, flush and reset.
module hdlc_rx_queue_bench;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic       push;
        logic [7:0] din;
        logic       pop;
        logic       es;
        logic       tx;
        logic [7:0] exp_head;
        logic       exp_avail;
        logic       exp_rxi;
        logic [7:0] exp_mon;
    } vec_t;

    // Mode 3, threshold 1, no tags
    localparam vec_t VECS [0:6] = '{
        '{1'b1, 8'hA1, 1'b0, 1'b1, 1'b0, 8'hA1, 1'b1, 1'b0, 8'h80},
        '{1'b1, 8'hB2, 1'b0, 1'b0, 1'b0, 8'hA1, 1'b1, 1'b1, 8'h20},
        '{1'b1, 8'hC3, 1'b0, 1'b0, 1'b1, 8'hA1, 1'b1, 1'b1, 8'h30},
        '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'hB2, 1'b1, 1'b1, 8'h20},
        '{1'b1, 8'hD4, 1'b1, 1'b0, 1'b0, 8'hC3, 1'b1, 1'b1, 8'h20},
        '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'hD4, 1'b1, 1'b0, 8'h00},
        '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00}
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       rx_valid, rx_last, rx_short, rd_strobe, err_reset, queue_flush;
    logic [7:0] rx_data;
    logic [1:0] int_mode, rx_threshold;
    logic       es_int_in, tx_int_in;
    logic [7:0] rd_data, rx_status, int_monitor;
    logic       rx_avail, sp_int, rx_int;
    int         total = 0;
    int         bad = 0;
    bit         done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    hdlc_rx_queue u_hdlc_rx_queue (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_last(rx_last), .rx_short(rx_short), .rd_strobe(rd_strobe),
        .err_reset(err_reset), .queue_flush(queue_flush), .int_mode(int_mode),
        .rx_threshold(rx_threshold), .es_int_in(es_int_in), .tx_int_in(tx_int_in),
        .rd_data(rd_data), .rx_avail(rx_avail), .rx_status(rx_status),
        .int_monitor(int_monitor), .sp_int(sp_int), .rx_int(rx_int)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One clocked cycle of stimulus, starting and ending at a falling edge
    task automatic step(input logic push, input logic [7:0] d, input logic last,
                        input logic shrt, input logic pop, input logic er, input logic fl);
        rx_valid = push; rx_data = d; rx_last = last; rx_short = shrt;
        rd_strobe = pop; err_reset = er; queue_flush = fl;
        @(posedge clk);
        #1;
        rx_valid = 1'b0; rx_last = 1'b0; rx_short = 1'b0;
        rd_strobe = 1'b0; err_reset = 1'b0; queue_flush = 1'b0;
        @(negedge clk);
    endtask

    task automatic push_b(input logic [7:0] d, input logic last, input logic shrt);
        step(1'b1, d, last, shrt, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic read_b();
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic err_b();
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; rx_valid = 1'b0; rx_data = '0; rx_last = 1'b0; rx_short = 1'b0;
        rd_strobe = 1'b0; err_reset = 1'b0; queue_flush = 1'b0;
        int_mode = 2'd3; rx_threshold = 2'd1; es_int_in = 1'b0; tx_int_in = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // Reset state
        check("R1 reset avail", rx_avail, 0);
        check("R10 reset status", rx_status, 8'h00);
        check("R10 reset sp_int", sp_int, 0);
        check("R12 reset rx_int", rx_int, 0);
        check("R13 reset monitor", int_monitor, 8'h00);

        // Table walk: order, pops, threshold interrupt, monitor (R1 R12 R13)
        foreach (VECS[i]) begin
            es_int_in = VECS[i].es;
            tx_int_in = VECS[i].tx;
            step(VECS[i].push, VECS[i].din, 1'b0, 1'b0, VECS[i].pop, 1'b0, 1'b0);
            check("R1 avail", rx_avail, VECS[i].exp_avail);
            if (VECS[i].exp_avail) check("R1 head", rd_data, VECS[i].exp_head);
            check("R12 rx_int threshold", rx_int, VECS[i].exp_rxi);
            check("R13 monitor", int_monitor, VECS[i].exp_mon);
        end
        es_int_in = 1'b0;
        tx_int_in = 1'b0;

        // R4: threshold 0, event when last byte reaches head
        rx_threshold = 2'd0;
        push_b(8'h31, 1'b0, 1'b0);
        push_b(8'h32, 1'b1, 1'b0);
        check("R4 no eof at push", rx_status, 8'h00);
        read_b();
        check("R4 eof at head", rx_status, 8'h40);
        check("R4 sp_int", sp_int, 1);
        check("R4 head", rd_data, 8'h32);
        read_b();
        check("R9 locked head", rd_data, 8'h32);
        check("R9 locked avail", rx_avail, 1);
        push_b(8'h33, 1'b0, 1'b0);
        check("R2 locked drop ovr", rx_status, 8'hC0);
        check("R2 locked drop head", rd_data, 8'h32);
        err_b();
        check("R10 status cleared", rx_status, 8'h00);
        check("R10 sp cleared", sp_int, 0);
        check("R10 queue kept", rd_data, 8'h32);
        read_b();
        check("R10 only one byte kept", rx_avail, 0);

        // R5: nonzero threshold, event at push
        rx_threshold = 2'd2;
        push_b(8'h41, 1'b0, 1'b0);
        push_b(8'h42, 1'b1, 1'b0);
        check("R5 eof at push", rx_status, 8'h40);
        check("R5 sp_int", sp_int, 1);
        check("R5 head still first", rd_data, 8'h41);
        err_b();
        read_b();
        check("R5 no event at head", rx_status, 8'h00);
        read_b();
        check("R5 drained", rx_avail, 0);

        // R7 and R8: mode off
        int_mode = 2'd0;
        push_b(8'h61, 1'b1, 1'b0);
        check("R7 eof flag", rx_status, 8'h40);
        check("R7 no sp_int", sp_int, 0);
        check("R12 mode off rx_int", rx_int, 0);
        push_b(8'h62, 1'b0, 1'b0);
        check("R8 eof cleared by next frame", rx_status, 8'h00);
        read_b();
        read_b();
        check("R8 drained", rx_avail, 0);

        // R6: first-character mode
        int_mode = 2'd1;
        push_b(8'h71, 1'b1, 1'b0);
        check("R6 first no eof at push", rx_status, 8'h00);
        check("R12 first-char rx_int", rx_int, 1);
        read_b();
        check("R6 first eof at read", rx_status, 8'h40);
        check("R6 first sp_int", sp_int, 1);
        err_b();

        // R6: special-only mode
        int_mode = 2'd2;
        push_b(8'h72, 1'b1, 1'b0);
        check("R6 special no sp at push", sp_int, 0);
        check("R12 special rx_int", rx_int, 0);
        read_b();
        check("R6 special sp at read", sp_int, 1);
        err_b();

        // R3: short frame tag at head
        push_b(8'h81, 1'b0, 1'b1);
        check("R3 short flag", rx_status, 8'h01);
        check("R3 short sp_int", sp_int, 1);
        err_b();
        read_b();

        // R2: full queue overwrite of newest entry
        int_mode = 2'd0;
        push_b(8'h91, 1'b0, 1'b0);
        push_b(8'h92, 1'b0, 1'b0);
        push_b(8'h93, 1'b0, 1'b0);
        push_b(8'h94, 1'b0, 1'b0);
        check("R2 full no ovr", rx_status, 8'h00);
        push_b(8'h95, 1'b0, 1'b0);
        check("R2 overrun flag", rx_status, 8'h80);
        check("R3 overrun sp_int", sp_int, 1);
        err_b();
        check("R1 head 1", rd_data, 8'h91);
        read_b();
        check("R1 head 2", rd_data, 8'h92);
        read_b();
        check("R1 head 3", rd_data, 8'h93);
        read_b();
        check("R2 newest overwritten", rd_data, 8'h95);
        read_b();
        check("R1 drained", rx_avail, 0);

        // R11: flush while locked keeps status
        push_b(8'hA1, 1'b0, 1'b1);
        push_b(8'hA2, 1'b0, 1'b0);
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        check("R11 flush empties", rx_avail, 0);
        check("R11 status kept", rx_status, 8'h81);
        err_b();
        check("R10 clear after flush", rx_status, 8'h00);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule